// File: doc/BRIEF.md
# Shadowed 64-bit Time Register File

This block keeps a 64-bit nanosecond counter together with a signed 64-bit offset and a 64-bit alarm compare value. All of them are reached through a 32-bit register port: one valid strobe, a write flag, a word address and a data word. Each 64-bit value occupies two word addresses. The low word is held in a private shadow until the high word arrives. The high-word write then installs all 64 bits in one clock edge, so no partial value is ever live.

The reported time is the counter plus the offset, taken modulo 2^64. Software reads it low word first. That read also latches the upper half of the same sample, so the high-word read that follows matches it even if the counter carries across the 32-bit boundary in between. The alarm raises a sticky status flag and a one-cycle pulse the first time the reported time reaches or passes the committed compare value.

Top module: `tsr_top`

## Requirements
- R1: Word addresses: 0 counter low, 1 counter high, 2 offset low, 3 offset high, 4 alarm low, 5 alarm high, 6 time low (read), 7 time high (read), 8 status (bit 0 = alarm flag); other addresses read 0. A write to address 0 only loads a shadow word: the counter keeps running as before, and a read of address 0 or 1 returns the live counter.
- R2: A write to address 1 sets the counter to {written word, low shadow} in that clock edge.
- R3: The offset pair is written low then high; the high write commits {high, low shadow}. Reads of addresses 2 and 3 return the committed value, never a pending shadow.
- R4: The alarm pair at addresses 4 and 5 commits the same way, reads back the committed value, and each commit arms the alarm.
- R5: Time equals counter plus offset, where the offset is treated as signed two's complement and the sum wraps modulo 2^64.
- R6: A read of address 6 returns time bits 31:0 and latches time bits 63:32 of the same cycle; a later read of address 7 returns that latched word.
- R7: A read of address 7 with no new read of address 6 returns the last latched word again, not a fresh sample.
- R8: On each cycle with tick_en high the counter grows by INC_NS; in a cycle that commits the counter, the committed value wins and that increment is dropped.
- R9: While armed and time is at or above the alarm value (unsigned), the next edge sets the sticky alarm_flag, gives a one-cycle alarm_pulse and disarms; it fires once per commit.
- R10: Writing 1 to status bit 0 clears alarm_flag; writing 0 leaves it; a firing in the same cycle as the clear keeps the flag set.
- R11: After reset the counter, offset, alarm, latched word and flag are all zero and the alarm is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle as the read strobe |
| alarm_flag | output | 1 | Sticky alarm status |
| alarm_pulse | output | 1 | One-cycle alarm event |

## Verification
A broken shadow or commit path shows up at the very next read of the counter, offset or alarm words as a torn value: one half is old and the other new. A latch that samples the wrong cycle shows only when the counter carries between the low and high time reads. The bench forces this case by starting near the 32-bit boundary. A wrong armed state or compare shows within one cycle of the crossing, as a missing, early or repeated pulse. The reference model is compared every cycle, so such faults are reported in the cycle they occur.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TIME_W = 2 * WORD_W;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned NPAIR  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO = 4'd0, A_CNT_HI = 4'd1,
    A_OFS_LO = 4'd2, A_OFS_HI = 4'd3,
    A_ALM_LO = 4'd4, A_ALM_HI = 4'd5,
    A_NOW_LO = 4'd6, A_NOW_HI = 4'd7,
    A_STAT   = 4'd8
  } reg_addr_e;

  // counter plus signed offset, wrapping at 2^64
  function automatic logic [TIME_W-1:0] time_sum(input logic [TIME_W-1:0] cnt,
                                                 input logic [TIME_W-1:0] ofs);
    return cnt + ofs;
  endfunction

  // unsigned "reached or passed" compare
  function automatic logic time_reached(input logic [TIME_W-1:0] now,
                                        input logic [TIME_W-1:0] tgt);
    return now >= tgt;
  endfunction
endpackage

// File: rtl/tsr_shadow_pair.sv
module tsr_shadow_pair #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic [W-1:0]   wdata,
  output logic           load_stb,
  output logic [2*W-1:0] load_val,
  output logic [W-1:0]   lo_shadow
);
  logic [W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (wr_lo) lo_q <= wdata;
  end

  assign lo_shadow = lo_q;
  assign load_stb  = wr_hi;
  assign load_val  = {wdata, lo_q};
endmodule

// File: rtl/tsr_counter.sv
module tsr_counter #(
  parameter int unsigned TW     = 64,
  parameter int unsigned INC_NS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          load_stb,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] cnt_q
);
  localparam logic [TW-1:0] STEP = TW'(INC_NS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load_stb) cnt_q <= load_val;
    else if (tick_en)  cnt_q <= cnt_q + STEP;
  end
endmodule

// File: rtl/tsr_alarm.sv
module tsr_alarm #(
  parameter int unsigned TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_stb,
  input  logic [TW-1:0] load_val,
  input  logic [TW-1:0] now_val,
  input  logic          clr_req,
  output logic [TW-1:0] alarm_q,
  output logic          fire,
  output logic          flag_q,
  output logic          pulse_q
);
  import tsr_pkg::*;
  logic armed_q;

  assign fire = armed_q && !load_stb && time_reached(now_val, alarm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (load_stb) begin
        alarm_q <= load_val;
        armed_q <= 1'b1;
      end else if (fire) begin
        armed_q <= 1'b0;
      end
      if (fire)         flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
      pulse_q <= fire;
    end
  end
endmodule

// File: rtl/tsr_top.sv
module tsr_top #(
  parameter int unsigned INC_NS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        reg_valid,
  input  logic        reg_write,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        alarm_flag,
  output logic        alarm_pulse
);
  import tsr_pkg::*;

  logic wr_en, rd_en;
  assign wr_en = reg_valid && reg_write;
  assign rd_en = reg_valid && !reg_write;

  logic [NPAIR-1:0]              ld_stb;
  logic [TIME_W-1:0]             ld_val [NPAIR];
  logic [NPAIR-1:0][WORD_W-1:0]  sh_lo;

  // pair g owns word addresses 2g (low) and 2g+1 (high)
  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    tsr_shadow_pair #(.W(WORD_W)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (wr_en && reg_addr == ADDR_W'(2*g)),
      .wr_hi     (wr_en && reg_addr == ADDR_W'(2*g+1)),
      .wdata     (reg_wdata),
      .load_stb  (ld_stb[g]),
      .load_val  (ld_val[g]),
      .lo_shadow (sh_lo[g])
    );
  end

  logic [TIME_W-1:0] cnt_q, ofs_q, alarm_q, now_val;
  logic [WORD_W-1:0] snap_hi_q;
  logic              fire, clr_req;

  tsr_counter #(.TW(TIME_W), .INC_NS(INC_NS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .load_stb(ld_stb[0]), .load_val(ld_val[0]), .cnt_q(cnt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ofs_q <= '0;
    else if (ld_stb[1]) ofs_q <= ld_val[1];
  end

  assign now_val = time_sum(cnt_q, ofs_q);
  assign clr_req = wr_en && reg_addr == A_STAT && reg_wdata[0];

  tsr_alarm #(.TW(TIME_W)) u_alm (
    .clk(clk), .rst_n(rst_n),
    .load_stb(ld_stb[2]), .load_val(ld_val[2]),
    .now_val(now_val), .clr_req(clr_req),
    .alarm_q(alarm_q), .fire(fire),
    .flag_q(alarm_flag), .pulse_q(alarm_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            snap_hi_q <= '0;
    else if (rd_en && reg_addr == A_NOW_LO) snap_hi_q <= now_val[TIME_W-1:WORD_W];
  end

  always_comb begin
    reg_rdata = '0;
    if (rd_en) begin
      case (reg_addr)
        A_CNT_LO: reg_rdata = cnt_q[WORD_W-1:0];
        A_CNT_HI: reg_rdata = cnt_q[TIME_W-1:WORD_W];
        A_OFS_LO: reg_rdata = ofs_q[WORD_W-1:0];
        A_OFS_HI: reg_rdata = ofs_q[TIME_W-1:WORD_W];
        A_ALM_LO: reg_rdata = alarm_q[WORD_W-1:0];
        A_ALM_HI: reg_rdata = alarm_q[TIME_W-1:WORD_W];
        A_NOW_LO: reg_rdata = now_val[WORD_W-1:0];
        A_NOW_HI: reg_rdata = snap_hi_q;
        A_STAT:   reg_rdata = {{(WORD_W-1){1'b0}}, alarm_flag};
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tsr_chk.sv
module tsr_chk #(
  parameter int unsigned INC_NS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              wr_en,
  input logic              rd_en,
  input logic [3:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [2:0][31:0]  sh_lo,
  input logic [63:0]       cnt_q,
  input logic [63:0]       ofs_q,
  input logic [63:0]       alarm_q,
  input logic [63:0]       now_val,
  input logic [31:0]       snap_hi_q,
  input logic              fire,
  input logic              alarm_flag,
  input logic              alarm_pulse
);
  import tsr_pkg::*;

  p_lo_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == A_CNT_LO && !tick_en) |=> $stable(cnt_q));

  p_cnt_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == A_CNT_HI) |=> cnt_q == {$past(reg_wdata), $past(sh_lo[0])});

  p_ofs_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == A_OFS_HI) |=> ofs_q == {$past(reg_wdata), $past(sh_lo[1])});

  p_alm_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == A_ALM_HI) |=> alarm_q == {$past(reg_wdata), $past(sh_lo[2])});

  p_snap_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr == A_NOW_LO) |=>
      ((rd_en && reg_addr == A_NOW_HI) -> reg_rdata == $past(now_val[63:32])));

  p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && reg_addr == A_NOW_LO) |=> $stable(snap_hi_q));

  p_tick_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !(wr_en && reg_addr == A_CNT_HI)) |=> cnt_q == $past(cnt_q) + 64'(INC_NS));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !(wr_en && reg_addr == A_STAT && reg_wdata[0])) |=> alarm_flag);

  p_pulse_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> alarm_flag);

  p_fire_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(wr_en && reg_addr == A_ALM_HI)) |=> !fire);

  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == A_STAT && reg_wdata[0] && !fire) |=> !alarm_flag);
endmodule

bind tsr_top tsr_chk #(.INC_NS(INC_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
  .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sh_lo(sh_lo),
  .cnt_q(cnt_q), .ofs_q(ofs_q), .alarm_q(alarm_q), .now_val(now_val),
  .snap_hi_q(snap_hi_q), .fire(fire),
  .alarm_flag(alarm_flag), .alarm_pulse(alarm_pulse)
);

// File: tb/test_tsr_top.sv
module test_tsr_top;
  localparam int CLK_PERIOD = 10;
  localparam int INC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_on = 1'b0;
  logic b_v = 1'b0, b_w = 1'b0;
  logic [3:0]  b_a = '0;
  logic [31:0] b_d = '0;
  logic [31:0] rdata;
  logic flag, pulse;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsr_top #(.INC_NS(INC)) i_tsr_top (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_on),
    .reg_valid(b_v), .reg_write(b_w), .reg_addr(b_a), .reg_wdata(b_d),
    .reg_rdata(rdata), .alarm_flag(flag), .alarm_pulse(pulse)
  );

  // behavioural reference model
  logic [63:0] m_cnt, m_ofs, m_alm;
  logic [31:0] m_sh [3];
  logic [31:0] m_snap;
  logic m_armed, m_flag, m_pulse;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_ofs <= 0; m_alm <= 0; m_snap <= 0;
      m_sh[0] <= 0; m_sh[1] <= 0; m_sh[2] <= 0;
      m_armed <= 0; m_flag <= 0; m_pulse <= 0;
    end else begin
      logic wr, rd, alm_commit, hit;
      logic [63:0] now;
      wr = b_v && b_w;
      rd = b_v && !b_w;
      now = m_cnt + m_ofs;
      alm_commit = wr && b_a == 4'd5;
      hit = m_armed && !alm_commit && (now >= m_alm);
      if (wr && b_a <= 4'd5 && b_a[0] == 1'b0) m_sh[b_a >> 1] <= b_d;
      if (wr && b_a == 4'd1) m_cnt <= {b_d, m_sh[0]};
      else if (tick_on) m_cnt <= m_cnt + 64'(INC);
      if (wr && b_a == 4'd3) m_ofs <= {b_d, m_sh[1]};
      if (alm_commit) begin m_alm <= {b_d, m_sh[2]}; m_armed <= 1; end
      else if (hit) m_armed <= 0;
      if (hit) m_flag <= 1;
      else if (wr && b_a == 4'd8 && b_d[0]) m_flag <= 0;
      m_pulse <= hit;
      if (rd && b_a == 4'd6) m_snap <= now[63:32];
    end
  end

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    logic [63:0] now;
    now = m_cnt + m_ofs;
    case (a)
      4'd0: return m_cnt[31:0];
      4'd1: return m_cnt[63:32];
      4'd2: return m_ofs[31:0];
      4'd3: return m_ofs[63:32];
      4'd4: return m_alm[31:0];
      4'd5: return m_alm[63:32];
      4'd6: return now[31:0];
      4'd7: return m_snap;
      4'd8: return {31'd0, m_flag};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: check outputs, drive, check read data
  task automatic step(input logic v, input logic w, input logic [3:0] a,
                      input logic [31:0] d, input string tag);
    logic [31:0] e;
    @(negedge clk);
    check(flag === m_flag, "R9 flag", {31'd0, flag}, {31'd0, m_flag});
    check(pulse === m_pulse, "R9 pulse", {31'd0, pulse}, {31'd0, m_pulse});
    b_v = v; b_w = w; b_a = a; b_d = d;
    #1;
    if (v && !w) begin
      e = exp_read(a);
      check(rdata === e, tag, rdata, e);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, a, d, tag);
  endtask
  task automatic rd(input logic [3:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'd0, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'd0, 32'd0, "idle");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    for (int a = 0; a < 9; a++) rd(4'(a), "R11 reset value");
    // R1 low write alone changes nothing live
    wr(4'd0, 32'h0000_1234, "R1");
    rd(4'd0, "R1 counter low unchanged");
    rd(4'd1, "R1 counter high unchanged");
    // R2 high write commits
    wr(4'd1, 32'h0000_0005, "R2");
    rd(4'd0, "R2 counter low committed");
    rd(4'd1, "R2 counter high committed");
    // R8 ticking and commit during tick
    tick_on = 1'b1;
    idle(10);
    rd(4'd0, "R8 ticked counter");
    wr(4'd0, 32'h0000_0100, "R8");
    wr(4'd1, 32'h0000_0000, "R8");
    rd(4'd0, "R8 commit drops increment");
    tick_on = 1'b0;
    // R3 offset, pending shadow invisible
    wr(4'd2, 32'hFFFF_FC18, "R3");
    rd(4'd2, "R3 pending low hidden");
    rd(4'd3, "R3 pending high hidden");
    wr(4'd3, 32'hFFFF_FFFF, "R3");
    rd(4'd2, "R3 offset low");
    rd(4'd3, "R3 offset high");
    // R5 wrap: counter 500 plus offset -1000
    wr(4'd0, 32'd500, "R5"); wr(4'd1, 32'd0, "R5");
    rd(4'd6, "R5 time low wrapped");
    rd(4'd7, "R5 time high wrapped");
    // R6 carry between low and high reads
    wr(4'd2, 32'd0, "R6"); wr(4'd3, 32'd0, "R6");
    wr(4'd0, 32'hFFFF_FFE0, "R6"); wr(4'd1, 32'd0, "R6");
    tick_on = 1'b1;
    rd(4'd6, "R6 time low");
    idle(8);
    rd(4'd7, "R6 matching high after carry");
    rd(4'd1, "R6 live counter high carried");
    // R7 high read without new low read
    idle(3);
    rd(4'd7, "R7 stale high repeated");
    // R4 / R9 alarm
    tick_on = 1'b0;
    wr(4'd0, 32'd0, "R9"); wr(4'd1, 32'd0, "R9");
    wr(4'd4, 32'd200, "R4");
    rd(4'd4, "R4 pending alarm hidden");
    wr(4'd5, 32'd0, "R4");
    rd(4'd4, "R4 alarm low");
    rd(4'd5, "R4 alarm high");
    tick_on = 1'b1;
    idle(35);
    rd(4'd8, "R9 flag set after crossing");
    idle(10);
    // R10 clear behaviour
    wr(4'd8, 32'd0, "R10");
    rd(4'd8, "R10 write zero keeps flag");
    wr(4'd8, 32'd1, "R10");
    rd(4'd8, "R10 write one clears");
    idle(10);
    rd(4'd8, "R9 no refire while disarmed");
    // re-arm with a target already passed
    wr(4'd4, 32'd16, "R9"); wr(4'd5, 32'd0, "R9");
    idle(4);
    rd(4'd8, "R9 immediate refire");
    tick_on = 1'b0;
    idle(2);
    summary();
  end
endmodule